// File: doc/BRIEF.md
# Card Interrupt Status and Control Register

This block gathers the interrupt requests of a line-interface controller, of the HDLC controllers and of an internal periodic timer into a single host interrupt line. Software reads a byte-wide source register to learn which source is pending. It writes the same address to control card reset, the timer and the global interrupt enable. A second byte register holds the serial-bus enable and the interrupt line number, which other parts of the card use.

A parameter selects the polarity in which the sources are reported. In the inverted variant a pending source reads as 0, so a read that returns all three source bits set means this card is not interrupting. In the direct variant a pending source reads as 1. The timer runs for a parameterised number of clocks and then latches a request. Software acknowledges that request by writing the control value with the timer-clear bit set and then writing it again with that bit cleared.

Top module: `card_irq_ctrl`

## Requirements
- R1: After reset the control byte holds card reset = 1 and timer disable = 1, with every other control bit at 0. The second register reads 0x00, `sub_rst` is 1 and `host_irq` is 0.
- R2: `status0_rd[2:0]` reports the line controller at bit 0, the HDLC request at bit 1 and the timer request at bit 2. With ACTIVE_LOW = 1 each bit is 0 when its source is pending, so 3'b111 means nothing is pending. With ACTIVE_LOW = 0 each bit is 1 when pending, so 3'b000 means nothing is pending. Bits 7:5 read 0.
- R3: A write with `wr_sel` = 0 stores `wr_data[4:0]` as the control byte from the next cycle on. The bits decode as bit 0 card reset, bit 1 timer disable, bit 2 timer clear, bit 3 interrupt enable and bit 4 test. `status0_rd[4]` reads back the test bit and `status0_rd[3]` reads back the interrupt enable.
- R4: A write with `wr_sel` = 1 stores the whole byte, which `status1_rd` returns from the next cycle on. `iom_en` is bit 7 of that byte and `irq_sel` is bits 3:0.
- R5: `host_irq` is 1 exactly when interrupt enable is set and at least one of the three sources is pending. It responds to the request inputs in the same cycle.
- R6: `sub_rst` follows the card reset bit. While card reset is set, the timer counter stays at zero and the timer request is cleared.
- R7: While the timer is enabled and card reset and timer clear are all 0, the timer request sets after TIMER_TICKS clock edges. It then stays set until timer clear is written. The write that sets timer clear drops the request at its own edge. While timer clear stays set, the counter is held at zero, and counting restarts after the write that clears timer clear.
- R8: While timer disable is set the counter stays at zero and no new timer request appears, but a request that is already latched is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control/source register, 1 selects the second register |
| wr_data | input | 8 | Write data |
| line_req | input | 1 | Line-interface controller request, active high |
| hdlc_req | input | 1 | HDLC controller request, active high |
| status0_rd | output | 8 | Source bits in the selected polarity, plus readback of the test and enable bits |
| status1_rd | output | 8 | Second register readback |
| host_irq | output | 1 | Merged host interrupt, active high |
| sub_rst | output | 1 | Reset to the sub-controllers |
| iom_en | output | 1 | Serial-bus interface enable |
| irq_sel | output | 4 | Interrupt line select |

## Verification
The request inputs reach `status0_rd` and `host_irq` in the same cycle, with no register in between. A register write shows at the outputs one edge after its strobe. The timer request appears TIMER_TICKS edges after the last write that enables the timer, and a write that sets timer clear removes the request at its own edge. The bench changes its inputs after the falling edge and compares every output just after that. At that point the result of every earlier rising edge has settled, and the same-cycle response to the new inputs is also present. The model applies each rising edge to its own integer counter and pending flag at that same edge, so every result is compared in the exact cycle in which it is due. Two instances, one for each polarity, receive identical stimulus.

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl #(
  parameter bit ACTIVE_LOW  = 1'b1,
  parameter int TIMER_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       line_req,
  input  logic       hdlc_req,
  output logic [7:0] status0_rd,
  output logic [7:0] status1_rd,
  output logic       host_irq,
  output logic       sub_rst,
  output logic       iom_en,
  output logic [3:0] irq_sel
);
  localparam int              CW   = $clog2(TIMER_TICKS + 1);
  localparam logic [CW-1:0]   LAST = CW'(TIMER_TICKS - 1);
  localparam logic [4:0]      CTRL_INIT = 5'b00011;

  logic [4:0]    ctrl;
  logic [7:0]    cfg1;
  logic [CW-1:0] cnt;
  logic          tpend;
  logic          wr0, wr1, clr_now, run;
  logic [2:0]    src;

  assign wr0     = wr_en & ~wr_sel;
  assign wr1     = wr_en & wr_sel;
  assign clr_now = ctrl[2] | (wr0 & wr_data[2]);
  assign run     = ~ctrl[0] & ~ctrl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_INIT;
      cfg1 <= 8'h00;
    end else begin
      if (wr0) ctrl <= wr_data[4:0];
      if (wr1) cfg1 <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      tpend <= 1'b0;
    end else if (clr_now || ctrl[0]) begin
      cnt   <= '0;
      tpend <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      tpend <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  assign src        = {tpend, hdlc_req, line_req};
  assign status0_rd = {3'b000, ctrl[4:3], (ACTIVE_LOW ? ~src : src)};
  assign status1_rd = cfg1;
  assign host_irq   = ctrl[3] & (|src);
  assign sub_rst    = ctrl[0];
  assign iom_en     = cfg1[7];
  assign irq_sel    = cfg1[3:0];
endmodule

module card_irq_ctrl_chk #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       line_req,
  input logic       hdlc_req,
  input logic [7:0] status0_rd,
  input logic [7:0] status1_rd,
  input logic       host_irq,
  input logic       sub_rst
);
  logic [2:0] pend_view;
  assign pend_view = ACTIVE_LOW ? ~status0_rd[2:0] : status0_rd[2:0];

  assert_idle_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_view == 3'b000) |-> !host_irq);

  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> status0_rd[3]);

  assert_line_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_view[0] == line_req);

  assert_test_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (status0_rd[4] == $past(wr_data[4])));

  assert_cfg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (status1_rd == $past(wr_data)));

  assert_reset_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[0]) |=> sub_rst);

  assert_timer_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[2]) |=> !pend_view[2]);
endmodule

bind card_irq_ctrl card_irq_ctrl_chk #(.ACTIVE_LOW(ACTIVE_LOW)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .line_req(line_req), .hdlc_req(hdlc_req), .status0_rd(status0_rd),
  .status1_rd(status1_rd), .host_irq(host_irq), .sub_rst(sub_rst)
);

// File: tb/sim_card_irq_ctrl.sv
module sim_card_irq_ctrl;
  localparam int TICKS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, line_req = 1'b0, hdlc_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] s0_a, s1_a, s0_b, s1_b;
  logic irq_a, rst_a, iom_a, irq_b, rst_b, iom_b;
  logic [3:0] sel_a, sel_b;

  always #4 clk = ~clk;

  card_irq_ctrl #(.ACTIVE_LOW(1'b1), .TIMER_TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_req(line_req), .hdlc_req(hdlc_req), .status0_rd(s0_a), .status1_rd(s1_a),
    .host_irq(irq_a), .sub_rst(rst_a), .iom_en(iom_a), .irq_sel(sel_a));

  card_irq_ctrl #(.ACTIVE_LOW(1'b0), .TIMER_TICKS(TICKS)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_req(line_req), .hdlc_req(hdlc_req), .status0_rd(s0_b), .status1_rd(s1_b),
    .host_irq(irq_b), .sub_rst(rst_b), .iom_en(iom_b), .irq_sel(sel_b));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  bit [4:0] m_ctrl = 5'b00011;
  bit [7:0] m_cfg = 8'h00;
  int       m_cnt = 0;
  bit       m_pend = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    bit [2:0] src;
    bit any;
    src = {m_pend, hdlc_req, line_req};
    any = |src;
    chk("R2 R3 status0 inverted", s0_a, {3'b000, m_ctrl[4:3], ~src});
    chk("R2 R3 status0 direct",   s0_b, {3'b000, m_ctrl[4:3], src});
    chk("R4 status1", s1_a, m_cfg);
    chk("R4 status1 direct", s1_b, m_cfg);
    chk("R4 iom_en/irq_sel", {3'b000, iom_a, sel_a}, {3'b000, m_cfg[7], m_cfg[3:0]});
    chk("R5 host_irq", {6'b0, irq_a, irq_b}, {6'b0, m_ctrl[3] & any, m_ctrl[3] & any});
    chk("R6 sub_rst", {6'b0, rst_a, rst_b}, {6'b0, m_ctrl[0], m_ctrl[0]});
  endtask

  task automatic model_edge(bit we, bit sel, bit [7:0] d);
    bit clr;
    clr = m_ctrl[2] | (we & ~sel & d[2]);
    if (clr || m_ctrl[0]) begin
      m_cnt = 0; m_pend = 0;
    end else if (m_ctrl[1]) begin
      m_cnt = 0;
    end else if (m_cnt == TICKS - 1) begin
      m_cnt = 0; m_pend = 1;
    end else begin
      m_cnt++;
    end
    if (we && !sel) m_ctrl = d[4:0];
    if (we && sel)  m_cfg = d;
  endtask

  task automatic cyc(bit lr, bit hr, bit we, bit sel, bit [7:0] d);
    @(negedge clk);
    line_req = lr; hdlc_req = hr; wr_en = we; wr_sel = sel; wr_data = d;
    #1;
    compare();
    @(posedge clk);
    model_edge(we, sel, d);
  endtask

  task automatic idle(int n, bit lr, bit hr);
    for (int i = 0; i < n; i++) cyc(lr, hr, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1 reset state, observed while reset is held and just after release
    @(negedge clk); #1; compare();
    @(negedge clk); rst_n = 1'b1;
    #1; compare();
    @(posedge clk);
    // R5 requests with interrupt disabled; R6 timer stopped in card reset
    idle(3, 1'b1, 1'b0);
    idle(3, 1'b0, 1'b1);
    idle(TICKS + 4, 1'b0, 1'b0);
    // R3 release reset, enable timer and interrupt
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h08);
    idle(2, 1'b1, 1'b0);
    idle(2, 1'b0, 1'b1);
    idle(2, 1'b1, 1'b1);
    // R7 timer fires and holds
    idle(TICKS + 6, 1'b0, 1'b0);
    // R7 acknowledge: set clear then drop it
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h0C);
    idle(TICKS + 2, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h08);
    idle(TICKS + 3, 1'b0, 1'b0);
    // R8 disable keeps latched request and stops new ones
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h0A);
    idle(3, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h0E);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h0A);
    idle(2 * TICKS, 1'b0, 1'b0);
    // R3 test bit, interrupt off
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h10);
    idle(TICKS + 2, 1'b1, 1'b0);
    // R6 card reset clears latched timer
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h19);
    idle(4, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h08);
    idle(TICKS - 2, 1'b0, 1'b0);
    // R4 second register
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h85);
    idle(2, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h7F);
    idle(2, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'hF0);
    idle(TICKS, 1'b1, 1'b1);
    finish_run();
  end
endmodule